// File: doc/BRIEF.md
# Packet Timestamp Capture Latch

This block records the value of the free-running system time counter at the moment a precision-time event message starts crossing the MAC, once for each direction. A start-of-frame strobe arrives together with fields already pulled from the frame by an upstream parser: ethertype, UDP destination port, message type and protocol version. When the frame qualifies, the live 64-bit counter value is copied into that direction's stamp slot and the slot locks. A locked slot ignores every later frame until software reads the upper stamp word. That read returns the data, clears the valid flag and frees the slot.

The transmit side has no filter. The MAC marks at most one outgoing frame for stamping, and that frame is captured when transmit stamping is enabled. The receive side has a filter with two modes. The first is UDP version-1 mode: only one programmed version-1 message code, such as Sync or Delay_Req, sent to the programmed UDP event port is stamped. The second is version-2 event mode: every version-2 event message is stamped, carried either over UDP to the event port or over layer 2 with a programmed ethertype. Software reaches the controls, the stamps, the match word and the ethertype filter word through a small register port. Read data comes back one cycle after the read strobe.

Top module: `ptp_stamp_latch`

## Requirements
- R1: After reset, every register reads as zero. Both slots are unlocked and both directions are disabled.
- R2: Register map, all words 32 bits wide.
  - Address 0 is transmit control: bit0 enable, bit1 valid (read-only).
  - Address 1 is receive control: bit0 enable, bit1 valid (read-only), bits 3:2 mode. Mode 01 is UDP version-1 and mode 10 is version-2 event.
  - Addresses 2 and 3 hold the transmit stamp low and high words. Addresses 4 and 5 hold the receive stamp low and high words.
  - Address 6 is the match word: UDP port in bits 31:16, version-1 message code in bits 7:0.
  - Address 7 is the ethertype filter: bit31 filter on, bit30 stamp on, ethertype in bits 15:0.
  - Read data appears one cycle after the read strobe.
- R3: On a transmit strobe with the mark bit set, transmit enable set and the slot unlocked, the slot stores the counter value present at that clock edge and sets valid.
- R4: A transmit frame without the mark bit, or one sent while transmit enable is clear, is not stamped.
- R5: While a slot is valid, later qualifying frames in that direction do not change the stored stamp.
- R6: Reading a high stamp word returns stamp bits 63:32 and clears that direction's valid flag, so the next qualifying frame is stamped again.
- R7: Reading a low stamp word returns stamp bits 31:0 and leaves the slot locked, however many times it is read.
- R8: In UDP version-1 mode, a receive frame is stamped only when all of the following hold: the version is 1, a UDP header is present, the destination port equals the match port, and the message code equals the match code.
- R9: In version-2 event mode, a receive frame is stamped only when both of the following hold:
  - The version is 2 and message-type bits 3:0 are in the range 0 to 3.
  - Either it is UDP to the match port, or it is a layer-2 frame whose ethertype equals the filter ethertype while both filter bits 31 and 30 are set.
- R10: Receive modes 00 and 11 stamp nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| time_now | input | 64 | Live system time counter |
| tx_sof | input | 1 | Transmit start-of-frame strobe |
| tx_mark | input | 1 | Frame is marked for stamping |
| rx_sof | input | 1 | Receive start-of-frame strobe |
| rx_ethertype | input | 16 | Parsed ethertype |
| rx_udp_valid | input | 1 | Frame carries a UDP header |
| rx_udp_dport | input | 16 | Parsed UDP destination port |
| rx_msg_type | input | 8 | Message type or version-1 control code |
| rx_version | input | 4 | Protocol version |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the strobe |

## Verification
The bench sends a second qualifying frame into a locked slot. A design without the lock would report the second counter value instead of the first. It reads the low word repeatedly before the high word, which catches a design that unlocks on any stamp read. It also confirms that a high-word read makes the slot capture again, which catches a design that never releases the slot. Receive frames that fail the filter one field at a time (wrong version, port, code or message type, and a half-enabled ethertype filter) expose any term missing from the match equations.

// File: rtl/ptp_stamp_pkg.sv
package ptp_stamp_pkg;
  localparam int REG_AW = 3;
  localparam int REG_DW = 32;

  typedef enum logic [REG_AW-1:0] {
    A_TXCTL = 3'd0,
    A_RXCTL = 3'd1,
    A_TXLO  = 3'd2,
    A_TXHI  = 3'd3,
    A_RXLO  = 3'd4,
    A_RXHI  = 3'd5,
    A_MATCH = 3'd6,
    A_ETF   = 3'd7
  } reg_addr_e;

  typedef enum logic [1:0] {
    RXM_NONE   = 2'd0,
    RXM_V1_UDP = 2'd1,
    RXM_V2_EVT = 2'd2,
    RXM_RSVD   = 2'd3
  } rx_mode_e;

  localparam int DIR_TX = 0;
  localparam int DIR_RX = 1;
  localparam int N_DIR  = 2;
endpackage

// File: rtl/ptp_rx_filter.sv
module ptp_rx_filter
  import ptp_stamp_pkg::*;
#(
  parameter int PORT_W = 16,
  parameter int ET_W   = 16,
  parameter int MSG_W  = 8,
  parameter int VER_W  = 4
) (
  input  rx_mode_e          mode,
  input  logic [31:0]       match_word,
  input  logic [31:0]       etf_word,
  input  logic [ET_W-1:0]   ethertype,
  input  logic              udp_valid,
  input  logic [PORT_W-1:0] udp_dport,
  input  logic [MSG_W-1:0]  msg_type,
  input  logic [VER_W-1:0]  version,
  output logic              hit
);
  localparam int MATCH_PORT_LSB = 16;
  localparam int ETF_ON_BIT     = 31;
  localparam int ETF_STAMP_BIT  = 30;

  logic udp_port_ok;
  logic l2_ok;
  logic v1_ok;
  logic v2_event;

  always_comb begin
    udp_port_ok = udp_valid &&
                  (udp_dport == match_word[MATCH_PORT_LSB +: PORT_W]);
    l2_ok       = etf_word[ETF_ON_BIT] && etf_word[ETF_STAMP_BIT] &&
                  (ethertype == etf_word[ET_W-1:0]);
    v1_ok       = (version == VER_W'(1)) && udp_port_ok &&
                  (msg_type == match_word[MSG_W-1:0]);
    v2_event    = (version == VER_W'(2)) && (msg_type[3:2] == 2'b00);
    unique case (mode)
      RXM_V1_UDP: hit = v1_ok;
      RXM_V2_EVT: hit = v2_event && (udp_port_ok || l2_ok);
      default:    hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/ptp_stamp_slot.sv
module ptp_stamp_slot #(
  parameter int TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              capture,
  input  logic [TIME_W-1:0] time_in,
  input  logic              release_rd,
  output logic              valid,
  output logic [TIME_W-1:0] stamp
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      stamp <= '0;
    end else if (!valid && enable && capture) begin
      valid <= 1'b1;
      stamp <= time_in;
    end else if (release_rd) begin
      valid <= 1'b0;
    end
  end

  // R5
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && !release_rd) |=> (valid && $stable(stamp)));

  // R6
  release_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && release_rd) |=> !valid);

  // R4
  disabled_chk: assert property (@(posedge clk) disable iff (rst)
    (!valid && !enable) |=> !valid);
endmodule

// File: rtl/ptp_stamp_latch.sv
module ptp_stamp_latch
  import ptp_stamp_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int PORT_W = 16,
  parameter int ET_W   = 16,
  parameter int MSG_W  = 8,
  parameter int VER_W  = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [TIME_W-1:0]   time_now,
  input  logic                tx_sof,
  input  logic                tx_mark,
  input  logic                rx_sof,
  input  logic [ET_W-1:0]     rx_ethertype,
  input  logic                rx_udp_valid,
  input  logic [PORT_W-1:0]   rx_udp_dport,
  input  logic [MSG_W-1:0]    rx_msg_type,
  input  logic [VER_W-1:0]    rx_version,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic [REG_DW-1:0]   reg_wdata,
  output logic [REG_DW-1:0]   reg_rdata
);
  localparam int HALF_W = TIME_W / 2;

  logic              en_q   [N_DIR];
  rx_mode_e          rx_mode_q;
  logic [31:0]       match_q;
  logic [31:0]       etf_q;
  logic              rx_hit;
  logic              cap    [N_DIR];
  logic              rel    [N_DIR];
  logic              vld    [N_DIR];
  logic [TIME_W-1:0] stamp  [N_DIR];

  ptp_rx_filter #(
    .PORT_W(PORT_W), .ET_W(ET_W), .MSG_W(MSG_W), .VER_W(VER_W)
  ) u_filter (
    .mode       (rx_mode_q),
    .match_word (match_q),
    .etf_word   (etf_q),
    .ethertype  (rx_ethertype),
    .udp_valid  (rx_udp_valid),
    .udp_dport  (rx_udp_dport),
    .msg_type   (rx_msg_type),
    .version    (rx_version),
    .hit        (rx_hit)
  );

  always_comb begin
    cap[DIR_TX] = tx_sof && tx_mark;
    cap[DIR_RX] = rx_sof && rx_hit;
    rel[DIR_TX] = reg_rd && (reg_addr == A_TXHI);
    rel[DIR_RX] = reg_rd && (reg_addr == A_RXHI);
  end

  for (genvar d = 0; d < N_DIR; d++) begin : g_slot
    ptp_stamp_slot #(.TIME_W(TIME_W)) u_slot (
      .clk        (clk),
      .rst        (rst),
      .enable     (en_q[d]),
      .capture    (cap[d]),
      .time_in    (time_now),
      .release_rd (rel[d]),
      .valid      (vld[d]),
      .stamp      (stamp[d])
    );
  end

  // control and filter registers
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q[DIR_TX] <= 1'b0;
      en_q[DIR_RX] <= 1'b0;
      rx_mode_q    <= RXM_NONE;
      match_q      <= '0;
      etf_q        <= '0;
    end else if (reg_wr) begin
      unique case (reg_addr)
        A_TXCTL: en_q[DIR_TX] <= reg_wdata[0];
        A_RXCTL: begin
          en_q[DIR_RX] <= reg_wdata[0];
          rx_mode_q    <= rx_mode_e'(reg_wdata[3:2]);
        end
        A_MATCH: match_q <= reg_wdata;
        A_ETF:   etf_q   <= reg_wdata;
        default: ;
      endcase
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      unique case (reg_addr)
        A_TXCTL: reg_rdata <= {30'd0, vld[DIR_TX], en_q[DIR_TX]};
        A_RXCTL: reg_rdata <= {28'd0, rx_mode_q, vld[DIR_RX], en_q[DIR_RX]};
        A_TXLO:  reg_rdata <= REG_DW'(stamp[DIR_TX][HALF_W-1:0]);
        A_TXHI:  reg_rdata <= REG_DW'(stamp[DIR_TX][TIME_W-1:HALF_W]);
        A_RXLO:  reg_rdata <= REG_DW'(stamp[DIR_RX][HALF_W-1:0]);
        A_RXHI:  reg_rdata <= REG_DW'(stamp[DIR_RX][TIME_W-1:HALF_W]);
        A_MATCH: reg_rdata <= match_q;
        default: reg_rdata <= etf_q;
      endcase
    end
  end

  // R10
  rx_off_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_mode_q == RXM_NONE || rx_mode_q == RXM_RSVD) |=> !$rose(vld[DIR_RX]));

  // R3
  tx_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(vld[DIR_TX]) |-> $past(tx_sof && tx_mark));

  // R8
  rx_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(vld[DIR_RX]) |-> $past(rx_sof));
endmodule

// File: tb/ptp_stamp_latch_test.sv
module ptp_stamp_latch_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] time_now = 64'h0000_0123_8000_0000;
  logic        tx_sof = 0, tx_mark = 0, rx_sof = 0;
  logic [15:0] rx_ethertype = 0;
  logic        rx_udp_valid = 0;
  logic [15:0] rx_udp_dport = 0;
  logic [7:0]  rx_msg_type = 0;
  logic [3:0]  rx_version = 0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) time_now <= time_now + 64'h0000_0001_0000_0007;

  ptp_stamp_latch uut (
    .clk(clk), .rst(rst), .time_now(time_now),
    .tx_sof(tx_sof), .tx_mark(tx_mark), .rx_sof(rx_sof),
    .rx_ethertype(rx_ethertype), .rx_udp_valid(rx_udp_valid),
    .rx_udp_dport(rx_udp_dport), .rx_msg_type(rx_msg_type),
    .rx_version(rx_version), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic send_tx(input logic mark, output logic [63:0] t);
    @(negedge clk); tx_sof = 1; tx_mark = mark; t = time_now;
    @(negedge clk); tx_sof = 0; tx_mark = 0;
  endtask

  task automatic send_rx(input logic [3:0] ver, input logic udp, input logic [15:0] port,
                         input logic [15:0] et, input logic [7:0] mt, output logic [63:0] t);
    @(negedge clk);
    rx_sof = 1; rx_version = ver; rx_udp_valid = udp; rx_udp_dport = port;
    rx_ethertype = et; rx_msg_type = mt; t = time_now;
    @(negedge clk); rx_sof = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      chk($sformatf("R1 reg %0d after reset", a), d, 32'h0);
    end
  endtask

  task automatic t_tx_basic();
    logic [63:0] t, dummy;
    logic [31:0] d;
    wr(3'd0, 32'h1);
    send_tx(1'b1, t);
    rd(3'd0, d); chk("R3 tx valid+enable", d, 32'h3);
    rd(3'd2, d); chk("R7 tx low first read", d, t[31:0]);
    rd(3'd2, d); chk("R7 tx low second read", d, t[31:0]);
    rd(3'd0, d); chk("R7 still locked after low reads", d, 32'h3);
    send_tx(1'b1, dummy);
    rd(3'd2, d); chk("R5 locked tx stamp kept", d, t[31:0]);
    rd(3'd3, d); chk("R6 tx high word", d, t[63:32]);
    rd(3'd0, d); chk("R6 tx valid cleared", d, 32'h1);
    send_tx(1'b1, t);
    rd(3'd2, d); chk("R6 tx recapture after release", d, t[31:0]);
    rd(3'd3, d);
  endtask

  task automatic t_tx_ignore();
    logic [63:0] t;
    logic [31:0] d;
    send_tx(1'b0, t);
    rd(3'd0, d); chk("R4 unmarked tx not stamped", d, 32'h1);
    wr(3'd0, 32'h0);
    send_tx(1'b1, t);
    rd(3'd0, d); chk("R4 disabled tx not stamped", d, 32'h0);
  endtask

  task automatic t_rx_v1();
    logic [63:0] t;
    logic [31:0] d;
    wr(3'd6, {16'd319, 16'h0000});
    rd(3'd6, d); chk("R2 match word readback", d, {16'd319, 16'h0000});
    wr(3'd1, 32'h5);
    send_rx(4'd2, 1'b1, 16'd319, 16'h0800, 8'h00, t);
    rd(3'd1, d); chk("R8 v1 mode rejects version 2", d, 32'h5);
    send_rx(4'd1, 1'b1, 16'd320, 16'h0800, 8'h00, t);
    rd(3'd1, d); chk("R8 v1 mode rejects port", d, 32'h5);
    send_rx(4'd1, 1'b1, 16'd319, 16'h0800, 8'h01, t);
    rd(3'd1, d); chk("R8 v1 mode rejects code", d, 32'h5);
    send_rx(4'd1, 1'b1, 16'd319, 16'h0800, 8'h00, t);
    rd(3'd1, d); chk("R8 v1 match stamped", d, 32'h7);
    rd(3'd4, d); chk("R8 rx low stamp", d, t[31:0]);
    rd(3'd5, d); chk("R6 rx high stamp", d, t[63:32]);
    rd(3'd1, d); chk("R6 rx valid cleared", d, 32'h5);
  endtask

  task automatic t_rx_v2();
    logic [63:0] t;
    logic [31:0] d;
    wr(3'd1, 32'h9);
    send_rx(4'd2, 1'b1, 16'd319, 16'h0800, 8'h02, t);
    rd(3'd1, d); chk("R9 v2 udp event stamped", d, 32'hB);
    rd(3'd5, d); chk("R9 v2 udp stamp high", d, t[63:32]);
    send_rx(4'd2, 1'b1, 16'd319, 16'h0800, 8'h08, t);
    rd(3'd1, d); chk("R9 v2 general msg rejected", d, 32'h9);
    send_rx(4'd2, 1'b0, 16'd0, 16'h88F7, 8'h00, t);
    rd(3'd1, d); chk("R9 l2 rejected without filter", d, 32'h9);
    wr(3'd7, 32'h8000_88F7);
    send_rx(4'd2, 1'b0, 16'd0, 16'h88F7, 8'h00, t);
    rd(3'd1, d); chk("R9 l2 rejected half filter", d, 32'h9);
    wr(3'd7, 32'hC000_88F7);
    send_rx(4'd2, 1'b0, 16'd0, 16'h88F7, 8'h03, t);
    rd(3'd1, d); chk("R9 l2 event stamped", d, 32'hB);
    rd(3'd4, d); chk("R9 l2 stamp low", d, t[31:0]);
    rd(3'd5, d);
  endtask

  task automatic t_rx_off();
    logic [63:0] t;
    logic [31:0] d;
    wr(3'd1, 32'h1);
    send_rx(4'd2, 1'b1, 16'd319, 16'h0800, 8'h00, t);
    rd(3'd1, d); chk("R10 mode 00 stamps nothing", d, 32'h1);
    wr(3'd1, 32'hD);
    send_rx(4'd1, 1'b1, 16'd319, 16'h0800, 8'h00, t);
    rd(3'd1, d); chk("R10 mode 11 stamps nothing", d, 32'hD);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_tx_basic();
    t_tx_ignore();
    t_rx_v1();
    t_rx_v2();
    t_rx_off();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule